// File: doc/BRIEF.md
# Parallel Receive Sample-Enable Generator

This block decides, once per receive clock, whether the word on a parallel data bus should be captured. It drives a registered sample strobe and a one-cycle end-of-frame flag. The strobe can follow one of three sources: the level of an external enable, capture windows bounded by external enable pulses, or a software enable bit. The external enable is picked from a set of pad inputs and may be complemented before use.

In pulse operation, a rising edge of the conditioned enable opens a capture window. The window closes in one of two ways, chosen by a submode field. In the first, a second rising edge closes it, and two submode bits decide independently whether the word present on the opening pulse and the word present on the closing pulse are captured. In the second, the window closes once a programmed number of words has been captured, and the submode decides only whether the opening word counts as one of them. The configuration inputs are expected to come from a register kept outside this block. That register resets to pad 7, level mode, no inversion. The block itself holds no data and has no bus access.

Top module: `rx_smp_gen`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `sample_en` and `frame_end` are 0 and no capture window is open.
- R2: The conditioned enable is `pad_in[cfg_pad_sel]` XOR `cfg_inv`.
- R3: With `cfg_mode` = 0 (level), `sample_en` in the cycle after a clock edge equals the conditioned enable sampled at that edge.
- R4: With `cfg_mode` = 2 (software), `sample_en` in the cycle after a clock edge equals `cfg_sw_en` sampled at that edge.
- R5: With `cfg_mode` = 1 (pulse) and no window open, a pulse is a conditioned enable that is 1 at this edge and was 0 at the previous edge (the previous value is 0 right after reset). A pulse opens a window.
- R6: In submodes 0 to 3, the word on the opening pulse is captured when submode bit 1 is 0, the word on the closing pulse is captured when submode bit 0 is 0, and every word between the two pulses is captured.
- R7: In submodes 0 to 3, the next pulse closes the window and raises `frame_end` for one cycle, coincident with the strobe of the closing word. The closing pulse does not open a new window.
- R8: In submode 4 the opening word is captured and counted, and in submode 5 it is not. After that, every word is captured and counted. The window closes, with `frame_end` raised on the same cycle as the last strobe, when the count reaches `cfg_len`, or passes it if `cfg_len` was lowered.
- R9: In submodes 4 and 5 with `cfg_len` = 0, a pulse raises `frame_end` for one cycle, gives no strobe, and opens no window.
- R10: `cfg_mode` = 3, and pulse mode with submode 6 or 7, give no strobe and no `frame_end`, and close any open window.
- R11: Leaving pulse mode closes an open window without raising `frame_end`.
- R12: Both outputs are registered, so each reflects the inputs of the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive data-valid clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_mode | input | 2 | Strobe source: 0 level, 1 pulse, 2 software, 3 reserved |
| cfg_pad_sel | input | SEL_W (4) | Index of the pad input used as the external enable |
| cfg_inv | input | 1 | Complement the selected enable |
| cfg_sw_en | input | 1 | Software sample enable |
| cfg_submode | input | 3 | Pulse submode, 0 to 5 valid |
| cfg_len | input | LEN_W (12) | Word count for the length-terminated submodes |
| pad_in | input | NPAD (16) | Pad inputs |
| sample_en | output | 1 | Capture the current word |
| frame_end | output | 1 | One-cycle flag when a window closes |

## Verification
Suppose the window flag or the word counter holds the wrong value. At the ports this shows as strobes continuing after the expected close, or a `frame_end` one or more cycles too early or too late. It is visible on the cycle right after the edge where the model and the design disagree, because every output is a single register stage. A stale previous-enable register shows up as a missed or spurious window opening on the first pulse after reset or after a select change. The bench compares both outputs on every cycle against an independent model. It drives random enable pulse trains through every submode and length, together with directed zero-length, unit-length and mode-exit cases.

// File: rtl/rx_smp_pkg.sv
package rx_smp_pkg;

  typedef enum logic [1:0] {
    MODE_LEVEL = 2'd0,
    MODE_PULSE = 2'd1,
    MODE_SOFT  = 2'd2,
    MODE_RSVD  = 2'd3
  } smp_mode_e;

  typedef enum logic [1:0] {
    CNT_HOLD = 2'd0,
    CNT_CLR  = 2'd1,
    CNT_ONE  = 2'd2,
    CNT_INC  = 2'd3
  } cnt_op_e;

  // submodes 0..5 are defined, 6 and 7 reserved
  function automatic logic sub_valid(input logic [2:0] s);
    return (s < 3'd6);
  endfunction

  // submodes 4 and 5 end on a word count
  function automatic logic sub_by_len(input logic [2:0] s);
    return s[2];
  endfunction

  function automatic logic sub_take_first(input logic [2:0] s);
    return s[2] ? ~s[0] : ~s[1];
  endfunction

  function automatic logic sub_take_last(input logic [2:0] s);
    return ~s[0];
  endfunction

endpackage

// File: rtl/rx_en_cond.sv
module rx_en_cond #(
  parameter int NPAD  = 16,
  parameter int SEL_W = $clog2(NPAD)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPAD-1:0]  pad_in,
  input  logic [SEL_W-1:0] sel,
  input  logic             inv,
  output logic             en_now,
  output logic             en_rise
);
  logic en_prev;

  assign en_now  = pad_in[sel] ^ inv;
  assign en_rise = en_now & ~en_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_prev <= 1'b0;
    else        en_prev <= en_now;
  end
endmodule

// File: rtl/rx_len_ctr.sv
module rx_len_ctr
  import rx_smp_pkg::*;
#(
  parameter int LEN_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  cnt_op_e          op,
  input  logic [LEN_W-1:0] len,
  output logic             hit_next,
  output logic             len_zero,
  output logic             len_one
);
  localparam int XW = LEN_W + 1;

  logic [LEN_W-1:0] cnt;

  // true when one more counted word reaches or passes the limit
  function automatic logic reach(input logic [LEN_W-1:0] c, input logic [LEN_W-1:0] l);
    logic [XW-1:0] nxt;
    nxt = {1'b0, c} + XW'(1);
    return nxt >= {1'b0, l};
  endfunction

  assign hit_next = reach(cnt, len);
  assign len_zero = (len == '0);
  assign len_one  = (len == LEN_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else begin
      case (op)
        CNT_CLR:  cnt <= '0;
        CNT_ONE:  cnt <= LEN_W'(1);
        CNT_INC:  cnt <= cnt + LEN_W'(1);
        default:  cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/rx_pulse_win.sv
module rx_pulse_win
  import rx_smp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pulse_mode,
  input  logic [2:0] sub,
  input  logic       en_rise,
  input  logic       hit_next,
  input  logic       len_zero,
  input  logic       len_one,
  output logic       win_smp,
  output logic       win_end,
  output logic       win_active,
  output cnt_op_e    cnt_op
);
  logic nxt_active;
  logic by_len, take_first, take_last;

  assign by_len     = sub_by_len(sub);
  assign take_first = sub_take_first(sub);
  assign take_last  = sub_take_last(sub);

  always_comb begin
    win_smp    = 1'b0;
    win_end    = 1'b0;
    nxt_active = win_active;
    cnt_op     = CNT_HOLD;
    if (!pulse_mode) begin
      nxt_active = 1'b0;
      cnt_op     = CNT_CLR;
    end else if (!win_active) begin
      if (en_rise) begin
        if (by_len) begin
          if (len_zero) begin
            win_end = 1'b1;
          end else if (take_first) begin
            win_smp = 1'b1;
            if (len_one) win_end = 1'b1;
            else begin
              nxt_active = 1'b1;
              cnt_op     = CNT_ONE;
            end
          end else begin
            nxt_active = 1'b1;
            cnt_op     = CNT_CLR;
          end
        end else begin
          win_smp    = take_first;
          nxt_active = 1'b1;
        end
      end
    end else if (by_len) begin
      win_smp = 1'b1;
      cnt_op  = CNT_INC;
      if (hit_next) begin
        win_end    = 1'b1;
        nxt_active = 1'b0;
      end
    end else if (en_rise) begin
      win_smp    = take_last;
      win_end    = 1'b1;
      nxt_active = 1'b0;
    end else begin
      win_smp = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) win_active <= 1'b0;
    else        win_active <= nxt_active;
  end
endmodule

// File: rtl/rx_smp_gen.sv
module rx_smp_gen
  import rx_smp_pkg::*;
#(
  parameter int NPAD  = 16,
  parameter int LEN_W = 12,
  localparam int SEL_W = $clog2(NPAD)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       cfg_mode,
  input  logic [SEL_W-1:0] cfg_pad_sel,
  input  logic             cfg_inv,
  input  logic             cfg_sw_en,
  input  logic [2:0]       cfg_submode,
  input  logic [LEN_W-1:0] cfg_len,
  input  logic [NPAD-1:0]  pad_in,
  output logic             sample_en,
  output logic             frame_end
);
  logic    en_now, en_rise;
  logic    pulse_mode;
  logic    win_smp, win_end, win_active;
  logic    hit_next, len_zero, len_one;
  cnt_op_e cnt_op;
  logic    smp_nxt;

  rx_en_cond #(.NPAD(NPAD), .SEL_W(SEL_W)) u_cond (
    .clk(clk), .rst_n(rst_n), .pad_in(pad_in), .sel(cfg_pad_sel),
    .inv(cfg_inv), .en_now(en_now), .en_rise(en_rise)
  );

  assign pulse_mode = (cfg_mode == MODE_PULSE) && sub_valid(cfg_submode);

  rx_pulse_win u_win (
    .clk(clk), .rst_n(rst_n), .pulse_mode(pulse_mode), .sub(cfg_submode),
    .en_rise(en_rise), .hit_next(hit_next), .len_zero(len_zero),
    .len_one(len_one), .win_smp(win_smp), .win_end(win_end),
    .win_active(win_active), .cnt_op(cnt_op)
  );

  rx_len_ctr #(.LEN_W(LEN_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .op(cnt_op), .len(cfg_len),
    .hit_next(hit_next), .len_zero(len_zero), .len_one(len_one)
  );

  always_comb begin
    case (cfg_mode)
      MODE_LEVEL: smp_nxt = en_now;
      MODE_PULSE: smp_nxt = win_smp;
      MODE_SOFT:  smp_nxt = cfg_sw_en;
      default:    smp_nxt = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sample_en <= 1'b0;
      frame_end <= 1'b0;
    end else begin
      sample_en <= smp_nxt;
      frame_end <= win_end;
    end
  end
endmodule

// File: rtl/rx_smp_gen_chk.sv
module rx_smp_gen_chk #(
  parameter int NPAD  = 16,
  parameter int LEN_W = 12,
  parameter int SEL_W = $clog2(NPAD)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       cfg_mode,
  input logic [SEL_W-1:0] cfg_pad_sel,
  input logic             cfg_inv,
  input logic             cfg_sw_en,
  input logic [2:0]       cfg_submode,
  input logic [LEN_W-1:0] cfg_len,
  input logic [NPAD-1:0]  pad_in,
  input logic             sample_en,
  input logic             frame_end,
  input logic             win_active,
  input logic             en_rise
);
  // R3
  level_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode == 2'd0) |=> (sample_en == $past(pad_in[cfg_pad_sel] ^ cfg_inv)));

  // R4
  soft_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode == 2'd2) |=> (sample_en == $past(cfg_sw_en)));

  // R10
  rsvd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((cfg_mode == 2'd3) || (cfg_mode == 2'd1 && cfg_submode > 3'd5))
      |=> (!sample_en && !frame_end && !win_active));

  // R11
  exit_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode != 2'd1) |=> (!win_active && !frame_end));

  // R5
  open_on_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(win_active) |-> ($past(en_rise) && $past(cfg_mode) == 2'd1));

  // R7
  end_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |-> !win_active);

  // R9
  len_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode == 2'd1 && cfg_submode[2:1] == 2'b10 && cfg_len == '0 && !win_active)
      |=> !sample_en);

  // R1
  always_comb begin
    if (!rst_n) begin
      reset_quiet_chk: assert (!sample_en && !frame_end && !win_active);
    end
  end
endmodule

bind rx_smp_gen rx_smp_gen_chk #(.NPAD(NPAD), .LEN_W(LEN_W), .SEL_W(SEL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_pad_sel(cfg_pad_sel),
  .cfg_inv(cfg_inv), .cfg_sw_en(cfg_sw_en), .cfg_submode(cfg_submode),
  .cfg_len(cfg_len), .pad_in(pad_in), .sample_en(sample_en),
  .frame_end(frame_end), .win_active(win_active), .en_rise(en_rise)
);

// File: tb/rx_smp_gen_test.sv
module rx_smp_gen_test;
  localparam int NPAD  = 16;
  localparam int LEN_W = 12;
  localparam int SEL_W = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [1:0]       cfg_mode = 2'd0;
  logic [SEL_W-1:0] cfg_pad_sel = 4'd7;
  logic             cfg_inv = 1'b0;
  logic             cfg_sw_en = 1'b0;
  logic [2:0]       cfg_submode = 3'd0;
  logic [LEN_W-1:0] cfg_len = '0;
  logic [NPAD-1:0]  pad_in = '0;
  logic             sample_en, frame_end;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  // model state
  bit m_prev = 0;
  bit m_open = 0;
  int m_cnt  = 0;
  bit exp_s, exp_f;
  bit cur_en = 0;
  int strobes, ends;

  always #10 clk = ~clk;

  rx_smp_gen #(.NPAD(NPAD), .LEN_W(LEN_W)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_pad_sel(cfg_pad_sel),
    .cfg_inv(cfg_inv), .cfg_sw_en(cfg_sw_en), .cfg_submode(cfg_submode),
    .cfg_len(cfg_len), .pad_in(pad_in), .sample_en(sample_en), .frame_end(frame_end)
  );

  function automatic string tag_of(input logic [1:0] md, input logic [2:0] sb);
    if (md == 2'd0) return "R2 R3 R12";
    if (md == 2'd2) return "R4 R12";
    if (md == 2'd3 || sb > 3'd5) return "R10";
    if (sb < 3'd4) return "R5 R6 R7";
    return "R8 R9";
  endfunction

  // expected outputs for the current inputs, advancing the model
  task automatic model_step();
    bit e, p, first, last;
    int lim;
    e = pad_in[cfg_pad_sel] ^ cfg_inv;
    p = e && !m_prev;
    m_prev = e;
    exp_s = 0;
    exp_f = 0;
    lim = int'(cfg_len);
    if (cfg_mode == 2'd0) exp_s = e;
    else if (cfg_mode == 2'd2) exp_s = cfg_sw_en;
    if (cfg_mode != 2'd1 || cfg_submode > 3'd5) begin
      m_open = 0;
      m_cnt = 0;
    end else if (cfg_submode < 3'd4) begin
      first = (cfg_submode[1] == 1'b0);
      last  = (cfg_submode[0] == 1'b0);
      if (!m_open) begin
        if (p) begin exp_s = first; m_open = 1; end
      end else if (p) begin
        exp_s = last; exp_f = 1; m_open = 0;
      end else exp_s = 1;
    end else begin
      first = (cfg_submode == 3'd4);
      if (!m_open) begin
        if (p) begin
          if (lim == 0) exp_f = 1;
          else if (first) begin
            exp_s = 1;
            if (lim == 1) exp_f = 1;
            else begin m_open = 1; m_cnt = 1; end
          end else begin m_open = 1; m_cnt = 0; end
        end
      end else begin
        exp_s = 1;
        m_cnt++;
        if (m_cnt >= lim) begin exp_f = 1; m_open = 0; end
      end
    end
  endtask

  task automatic check(input string tag, input bit act, input bit expv, input string what);
    n_tests++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s %s: actual %0b expected %0b", tag, what, act, expv);
    end
  endtask

  // one clock: inputs already set at a falling edge
  task automatic cyc();
    string t;
    t = tag_of(cfg_mode, cfg_submode);
    model_step();
    @(posedge clk);
    @(negedge clk);
    check(t, sample_en, exp_s, "sample_en");
    check(t, frame_end, exp_f, "frame_end");
    strobes += int'(sample_en);
    ends    += int'(frame_end);
  endtask

  task automatic drive_en(input bit v);
    pad_in = NPAD'($urandom());
    pad_in[cfg_pad_sel] = v ^ cfg_inv;
  endtask

  task automatic pulse_run(input int n);
    for (int i = 0; i < n; i++) begin
      if ($urandom_range(3) == 0) cur_en = ~cur_en;
      drive_en(cur_en);
      cyc();
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R1: outputs quiet in reset, even with the selected pad high
    pad_in = '1;
    #1;
    check("R1", sample_en, 1'b0, "sample_en in reset");
    check("R1", frame_end, 1'b0, "frame_end in reset");
    pad_in = '0;
    rst_n = 1'b1;
    cyc();

    // R2 R3: level mode, plain and inverted, several pads
    for (int k = 0; k < 4; k++) begin
      cfg_mode = 2'd0;
      cfg_pad_sel = SEL_W'($urandom());
      cfg_inv = k[0];
      for (int i = 0; i < 30; i++) begin pad_in = NPAD'($urandom()); cyc(); end
    end

    // R4: software mode with pads toggling
    cfg_mode = 2'd2;
    for (int i = 0; i < 30; i++) begin
      cfg_sw_en = 1'($urandom()); pad_in = NPAD'($urandom()); cyc();
    end

    // R6 R7 R8: every pulse submode, both polarities
    cfg_mode = 2'd1;
    for (int s = 0; s < 6; s++) begin
      cfg_submode = 3'(s);
      cfg_inv = s[0];
      cfg_len = LEN_W'($urandom_range(1, 6));
      pulse_run(300);
    end

    // R8: submode 4, length 3, one pulse -> exactly 3 strobes, one end
    cfg_submode = 3'd4; cfg_inv = 0; cfg_len = 3;
    cur_en = 0; drive_en(0); cyc(); cyc();
    strobes = 0; ends = 0;
    drive_en(1); cyc();
    for (int i = 0; i < 8; i++) cyc();
    check("R8", 1'(strobes == 3), 1'b1, "three strobes for length 3 incl. start");
    check("R8", 1'(ends == 1), 1'b1, "single frame end for length 3");

    // R8: submode 5, length 2 -> start excluded, still 2 strobes
    cfg_submode = 3'd5; cfg_len = 2;
    drive_en(0); cyc();
    strobes = 0; ends = 0;
    drive_en(1); cyc();
    for (int i = 0; i < 6; i++) cyc();
    check("R8", 1'(strobes == 2), 1'b1, "two strobes for length 2 excl. start");

    // R9: length zero -> end flag, no strobe
    cfg_submode = 3'd4; cfg_len = 0;
    drive_en(0); cyc();
    strobes = 0; ends = 0;
    drive_en(1); cyc();
    for (int i = 0; i < 4; i++) cyc();
    check("R9", 1'(strobes == 0), 1'b1, "no strobes for zero length");
    check("R9", 1'(ends == 1), 1'b1, "one frame end for zero length");

    // R11: open a window, leave pulse mode, return with enable held high
    cfg_submode = 3'd0;
    drive_en(0); cyc();
    drive_en(1); cyc();
    cfg_mode = 2'd3; cyc();
    cfg_mode = 2'd1;
    strobes = 0; ends = 0;
    for (int i = 0; i < 5; i++) cyc();
    check("R11", 1'(strobes == 0 && ends == 0), 1'b1, "window dropped on mode exit");

    // R10: reserved mode and reserved submodes
    cfg_mode = 2'd3; pulse_run(40);
    cfg_mode = 2'd1; cfg_submode = 3'd6; pulse_run(40);
    cfg_submode = 3'd7; pulse_run(40);

    // mixed random configuration segments
    for (int seg = 0; seg < 60; seg++) begin
      cfg_mode    = 2'($urandom());
      cfg_submode = 3'($urandom());
      cfg_pad_sel = SEL_W'($urandom());
      cfg_inv     = 1'($urandom());
      cfg_len     = LEN_W'($urandom_range(0, 8));
      cfg_sw_en   = 1'($urandom());
      pulse_run(50);
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule